// File: doc/BRIEF.md
# Double-Buffered DAC Code Register

This block is the digital front end of a 12-bit converter. It keeps the code in two register stages. The input stage takes a parallel word from the data bus under a chip-select strobe and a write strobe. The DAC stage is driven by a separate load strobe, and it holds the code that goes to the converter. An active-low clear acts on the DAC stage only. All strobes are active low and asynchronous. They pass through a synchroniser and then act as level-sensitive enables: a stage follows its source while its strobes are low and keeps the last value when they are released.

The data bus is delayed by the same number of flops as the strobes, so a word and the strobes that qualify it stay aligned. The load strobe may move at any time with respect to the write strobe. When the two overlap, the load strobe must stay low for a minimum number of clock cycles after write rises. A one-cycle flag reports any release that comes earlier than that. A second output shows when clear is forcing the code to zero.

Top module: `dacbuf_top`

## Requirements
- R1: After reset, dac_code is 0, zero_force is 0 and hold_viol is 0.
- R2: While cs_n and wr_n are both low, the input stage takes din on every cycle. This can be seen at dac_code while ld_n is low.
- R3: While cs_n or wr_n is high, the input stage holds its value, and changes on din do not reach dac_code.
- R4: While ld_n is high and clr_n is high, dac_code holds. When ld_n returns low, dac_code takes the current input-stage word.
- R5: With cs_n, wr_n and ld_n all low, a change on din appears on dac_code exactly SYNC_STAGES+2 clock cycles after the change: not one cycle earlier, and it stays there.
- R6: While clr_n is low, dac_code is 0 and zero_force is 1, whatever the other strobes and din do.
- R7: If both stages are open, dac_code follows din again once clr_n returns high, and zero_force returns to 0.
- R8: If both stages are holding, a low pulse on clr_n leaves 0 in dac_code after clr_n returns high. The input stage keeps its word, and that word appears when ld_n next goes low.
- R9: wr_n may rise while ld_n is low. If ld_n then rises fewer than HOLD_CYC clock cycles after wr_n, hold_viol pulses high for exactly one cycle.
- R10: hold_viol stays 0 when ld_n stays low for HOLD_CYC or more cycles after wr_n rises. It also stays 0 when wr_n rises while ld_n is already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select for the input stage, active low, asynchronous |
| wr_n | input | 1 | Write strobe for the input stage, active low, asynchronous |
| ld_n | input | 1 | Load strobe for the DAC stage, active low, asynchronous |
| clr_n | input | 1 | Clear for the DAC stage, active low, asynchronous |
| din | input | DATA_W | Parallel data word |
| dac_code | output | DATA_W | Code presented to the converter |
| zero_force | output | 1 | High while clear is forcing the code to zero |
| hold_viol | output | 1 | One-cycle pulse when the load strobe is released too early after a write |

## Verification
The bench builds the block with DATA_W=12, SYNC_STAGES=2 and HOLD_CYC=4. With two synchroniser stages the bus-to-code latency is four cycles, so the bench can check the exact latency from both sides: the old code one cycle before the change and the new code on the cycle of the change. A hold window of four cycles is short enough that both edge cases fit in a few cycles each. One run releases load three cycles after write, which must flag. Another releases it four cycles after write, which must stay quiet. The clear tests are run once with both stages open and once with both stages holding, so the two clear outcomes can be told apart.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;

  // Synchronised strobe bundle, all active low
  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic ld_n;
    logic clr_n;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

  typedef enum logic {
    HM_IDLE  = 1'b0,
    HM_WATCH = 1'b1
  } hold_state_t;

endpackage

// File: rtl/sync_pipe.sv
module sync_pipe #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [W-1:0] nxt;
    logic [W-1:0] r;
    if (i == 0) begin : g_first
      assign nxt = d;
    end else begin : g_rest
      assign nxt = g_stg[i-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_VAL;
      else        r <= nxt;
    end
  end

  assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/input_stage.sv
module input_stage #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] word_q
);

  logic              open_en;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    open_en = ~cs_n & ~wr_n;
    word_d  = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (open_en) word_q <= word_d;
  end

endmodule

// File: rtl/dac_stage.sv
module dac_stage #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] code_q,
  output logic              zero_q
);

  logic              code_en;
  logic [DATA_W-1:0] code_d;

  always_comb begin
    code_en = ~clr_n | ~ld_n;
    code_d  = clr_n ? word_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      zero_q <= 1'b0;
    end else begin
      if (code_en) code_q <= code_d;
      zero_q <= ~clr_n;
    end
  end

endmodule

// File: rtl/hold_monitor.sv
module hold_monitor
  import dacbuf_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  input  logic ld_n,
  output logic viol_q
);

  localparam int               CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(HOLD_CYC - 1);

  hold_state_t      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_prev_q;
  logic             viol_d;
  logic             wr_rise;

  always_comb begin
    wr_rise = wr_n & ~wr_prev_q;
    st_d    = st_q;
    cnt_d   = cnt_q;
    viol_d  = 1'b0;
    if (st_q == HM_WATCH && ld_n) begin
      viol_d = (cnt_q < LAST);
      st_d   = HM_IDLE;
    end else if (wr_rise && !ld_n) begin
      st_d  = HM_WATCH;
      cnt_d = '0;
    end else if (st_q == HM_WATCH) begin
      if (cnt_q == LAST) st_d  = HM_IDLE;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= HM_IDLE;
      cnt_q     <= '0;
      wr_prev_q <= 1'b1;
      viol_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      wr_prev_q <= wr_n;
      viol_q    <= viol_d;
    end
  end

endmodule

// File: rtl/dacbuf_top.sv
module dacbuf_top
  import dacbuf_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dac_code,
  output logic              zero_force,
  output logic              hold_viol
);

  logic              rst_ns;
  strobe_t           stb_raw, stb_s;
  logic [DATA_W-1:0] din_d;
  logic [DATA_W-1:0] in_word;

  sync_pipe #(.W(1), .STAGES(2), .RST_VAL(1'b0)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ns)
  );

  assign stb_raw = '{cs_n: cs_n, wr_n: wr_n, ld_n: ld_n, clr_n: clr_n};

  sync_pipe #(.W(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL({STROBE_W{1'b1}}))
    stb_sync_i (.clk(clk), .rst_n(rst_ns), .d(stb_raw), .q(stb_s));

  sync_pipe #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0))
    din_align_i (.clk(clk), .rst_n(rst_ns), .d(din), .q(din_d));

  input_stage #(.DATA_W(DATA_W)) in_i (
    .clk(clk), .rst_n(rst_ns), .cs_n(stb_s.cs_n), .wr_n(stb_s.wr_n),
    .din(din_d), .word_q(in_word)
  );

  dac_stage #(.DATA_W(DATA_W)) dac_i (
    .clk(clk), .rst_n(rst_ns), .ld_n(stb_s.ld_n), .clr_n(stb_s.clr_n),
    .word_in(in_word), .code_q(dac_code), .zero_q(zero_force)
  );

  hold_monitor #(.HOLD_CYC(HOLD_CYC)) hold_i (
    .clk(clk), .rst_n(rst_ns), .wr_n(stb_s.wr_n), .ld_n(stb_s.ld_n),
    .viol_q(hold_viol)
  );

endmodule

// File: rtl/dacbuf_chk.sv
module dacbuf_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              s_cs,
  input logic              s_wr,
  input logic              s_ld,
  input logic              s_clr,
  input logic [DATA_W-1:0] din_d,
  input logic [DATA_W-1:0] in_word,
  input logic [DATA_W-1:0] dac_code,
  input logic              zero_force,
  input logic              hold_viol
);

  // R2
  in_follow_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!s_cs && !s_wr) |=> (in_word == $past(din_d)));

  // R3
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (s_cs || s_wr) |=> $stable(in_word));

  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (s_ld && s_clr) |=> $stable(dac_code));

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    zero_force |-> (dac_code == '0));

  // R6
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !s_clr |=> zero_force);

  // R9
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    hold_viol |-> $past(s_ld));

  // R9
  viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    hold_viol |=> !hold_viol);

endmodule

bind dacbuf_top dacbuf_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_ns(rst_ns),
  .s_cs(stb_s.cs_n), .s_wr(stb_s.wr_n), .s_ld(stb_s.ld_n), .s_clr(stb_s.clr_n),
  .din_d(din_d), .in_word(in_word), .dac_code(dac_code),
  .zero_force(zero_force), .hold_viol(hold_viol)
);

// File: tb/dacbuf_tb.sv
module dacbuf_top_tb_top;

  localparam int DATA_W = 12;
  localparam int SYNC   = 2;
  localparam int HOLD   = 4;
  localparam int LAT    = SYNC + 2;
  localparam int SETTLE = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dac_code;
  logic              zero_force, hold_viol;

  int total = 0;
  int bad = 0;
  int viol_cnt = 0;

  always #5 clk = ~clk;

  dacbuf_top #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
    .clr_n(clr_n), .din(din), .dac_code(dac_code),
    .zero_force(zero_force), .hold_viol(hold_viol)
  );

  always @(negedge clk) if (hold_viol) viol_cnt++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 code", dac_code, 0);
    chk("R1 zero_force", zero_force, 0);
    chk("R1 hold_viol", hold_viol, 0);
  endtask

  task automatic t_transparent();
    cs_n = 0; wr_n = 0; ld_n = 0; din = 12'hA5C;
    cyc(SETTLE);
    chk("R5 follow", dac_code, 12'hA5C);
    din = 12'h3E1;
    cyc(LAT - 1);
    chk("R5 not early", dac_code, 12'hA5C);
    cyc(1);
    chk("R5 on time", dac_code, 12'h3E1);
    din = 12'hFFF;
    cyc(SETTLE);
    chk("R5 all ones", dac_code, 12'hFFF);
  endtask

  task automatic t_input_hold();
    cs_n = 1; din = 12'h111;
    cyc(SETTLE);
    chk("R3 cs high", dac_code, 12'hFFF);
    cs_n = 0; wr_n = 1;
    cyc(2);
    din = 12'h222;
    cyc(SETTLE);
    chk("R3 wr high", dac_code, 12'hFFF);
    wr_n = 0;
    cyc(SETTLE);
    chk("R2 write opens", dac_code, 12'h222);
  endtask

  task automatic t_dac_hold();
    din = 12'h123;
    cyc(SETTLE);
    ld_n = 1;
    cyc(SETTLE);
    din = 12'h456;
    cyc(SETTLE);
    chk("R4 held", dac_code, 12'h123);
    ld_n = 0;
    cyc(SETTLE);
    chk("R4 load", dac_code, 12'h456);
  endtask

  task automatic t_clr_open();
    din = 12'h7FF;
    cyc(SETTLE);
    clr_n = 0;
    cyc(SETTLE);
    chk("R6 zero", dac_code, 0);
    chk("R6 flag", zero_force, 1);
    din = 12'h0AA;
    cyc(SETTLE);
    chk("R6 zero despite din", dac_code, 0);
    clr_n = 1;
    cyc(SETTLE);
    chk("R7 follows", dac_code, 12'h0AA);
    chk("R7 flag off", zero_force, 0);
  endtask

  task automatic t_clr_held();
    din = 12'h5A5;
    cyc(SETTLE);
    wr_n = 1; cs_n = 1; ld_n = 1;
    cyc(SETTLE);
    chk("R8 pre", dac_code, 12'h5A5);
    clr_n = 0;
    cyc(3);
    clr_n = 1;
    cyc(1);
    chk("R6 flag during pulse", zero_force, 1);
    cyc(SETTLE);
    chk("R8 zero stays", dac_code, 0);
    chk("R8 flag off", zero_force, 0);
    ld_n = 0;
    cyc(SETTLE);
    chk("R8 input kept", dac_code, 12'h5A5);
  endtask

  task automatic t_hold_viol();
    int v0;
    cs_n = 0; wr_n = 0; ld_n = 0;
    cyc(SETTLE);
    v0 = viol_cnt;
    wr_n = 1;
    cyc(HOLD - 1);
    ld_n = 1;
    cyc(SETTLE);
    chk("R9 early release", viol_cnt, v0 + 1);
    ld_n = 0; wr_n = 0;
    cyc(SETTLE);
  endtask

  task automatic t_hold_ok();
    int v0;
    v0 = viol_cnt;
    wr_n = 1;
    cyc(HOLD);
    ld_n = 1;
    cyc(SETTLE);
    chk("R10 exact hold", viol_cnt, v0);
    wr_n = 0;
    cyc(SETTLE);
    wr_n = 1;
    cyc(1);
    ld_n = 0;
    cyc(1);
    ld_n = 1;
    cyc(SETTLE);
    chk("R10 no overlap", viol_cnt, v0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(4);
    t_reset();
    t_transparent();
    t_input_hold();
    t_dac_hold();
    t_clr_open();
    t_clr_held();
    t_hold_viol();
    t_hold_ok();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule